// File: doc/BRIEF.md
# Video Line Timing and Burst Gate Generator

This block keeps the pixel and line position of interlaced 525-line (NTSC) and 625-line (PAL) video. It advances once per clock; the clock is the 13.5 MHz sample rate. From that position it produces an active-low composite sync and a burst gate (clamp) signal. The gate is raised for a short window after each horizontal sync, only on the lines that carry colour burst. Both outputs are decoded from the same counter registers, so they stay aligned with each other.

In master mode the counters free-run. In slave mode the counters still flywheel, but a leading edge on a horizontal strobe restarts the line, and a leading edge on a vertical strobe moves the line counter to the first line of a field. The strobes come either from dedicated pins or from flags decoded out of embedded timing reference codes. A standard-select input picks NTSC or PAL. It is sampled only when a new frame begins.

Top module: `vid_line_timer`

## Requirements
- R1: `rst_n` low resets the block at once, without waiting for a clock edge: `line_cnt` = 1, `pix_cnt` = 0, `pal_active` = 0 (NTSC), so `csync_n` = 0.
- R2: Each clock `pix_cnt` counts 0 up to PIX_NTSC-1 (858 samples by default) or PIX_PAL-1 (864) and then returns to 0. When it returns to 0, `line_cnt` advances, and after the last line (525 NTSC, 625 PAL) it goes back to 1.
- R3: `pal_active` (1 = PAL) takes the value of `pal_sel` only when a frame starts. A frame starts when the counter advances from the last line into line 1, or when a slave vertical edge arrives with field bit 0. At any other time a change of `pal_sel` has no effect.
- R4: On lines that are not vertical-sync lines, `csync_n` is 0 while `pix_cnt` < HS_W (64) and 1 otherwise.
- R5: The vertical-sync lines are 4–6 and 266–268 for NTSC and 1–3 and 313–315 for PAL. On these lines `csync_n` is 0 except during the last HS_W samples of the line.
- R6: `burst_gate` is 1 only when `pix_cnt` is in [BG_START, BG_START+BG_LEN) (default [76, 110)) on a burst line, and is never 1 while `csync_n` is 0. The burst lines are 10–263 and 273–525 for NTSC, and 6–310 and 319–623 for PAL.
- R7: In slave mode, a horizontal leading edge makes `pix_cnt` read 0 in the next cycle and advances `line_cnt` by one, wrapping as in R2.
- R8: In slave mode, a vertical leading edge sets `line_cnt` in the next cycle. With field bit 0 it becomes 1. With field bit 1 it becomes the first line of field two (264 NTSC, 314 PAL). This overrides any line advance in the same cycle.
- R9: With `use_codes` = 1 the strobes and field bit are taken from `code_h`, `code_v` and `code_f`, and `hs_in`, `vs_in` and `fld_in` are ignored. With `use_codes` = 0 the pins are used and the code flags are ignored.
- R10: A leading edge means the strobe is high in this cycle and was low in the previous one. A strobe held high causes only one restart. In master mode (`slave_en` = 0) all strobes are ignored and `pix_cnt` simply steps by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (13.5 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| pal_sel | input | 1 | Requested standard: 1 = PAL, 0 = NTSC |
| slave_en | input | 1 | 1 = lock to external strobes, 0 = free-run |
| use_codes | input | 1 | 1 = use code flags, 0 = use sync pins |
| hs_in | input | 1 | Horizontal strobe pin |
| vs_in | input | 1 | Vertical strobe pin |
| fld_in | input | 1 | Field bit pin (1 = field two) |
| code_h | input | 1 | Horizontal flag from reference-code decode |
| code_v | input | 1 | Vertical flag from reference-code decode |
| code_f | input | 1 | Field flag from reference-code decode |
| csync_n | output | 1 | Composite sync, active low |
| burst_gate | output | 1 | Clamp / burst gate |
| line_cnt | output | LW (10) | Current line, 1-based |
| pix_cnt | output | PW (10) | Current sample within the line |
| pal_active | output | 1 | Standard in effect |

## Verification
The situation that is hardest to reach is a change of standard: it takes effect only at a frame start, so checking both the refusal and the acceptance needs a whole frame of counting. The bench overrides the samples-per-line parameters to 40 and 44 while keeping the real line counts. This lets it run complete NTSC and PAL frames cycle by cycle against a reference position counter, with the standard request raised partway through a frame. The slave paths are then driven from a known position, including a vertical edge that reselects the standard and simultaneous horizontal and vertical edges.

// File: rtl/vid_line_timer.sv
module vid_line_timer #(
  parameter int PIX_NTSC   = 858,
  parameter int PIX_PAL    = 864,
  parameter int LINES_NTSC = 525,
  parameter int LINES_PAL  = 625,
  parameter int HS_W       = 64,
  parameter int BG_START   = 76,
  parameter int BG_LEN     = 34,
  parameter int VS_LEN     = 3,
  parameter int VS_N1      = 4,
  parameter int VS_N2      = 266,
  parameter int VS_P1      = 1,
  parameter int VS_P2      = 313,
  parameter int BG_N1      = 10,
  parameter int BG_N1E     = 263,
  parameter int BG_N2      = 273,
  parameter int BG_N2E     = 525,
  parameter int BG_P1      = 6,
  parameter int BG_P1E     = 310,
  parameter int BG_P2      = 319,
  parameter int BG_P2E     = 623,
  localparam int PW = $clog2(PIX_PAL > PIX_NTSC ? PIX_PAL : PIX_NTSC),
  localparam int LW = $clog2(LINES_PAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pal_sel,
  input  logic          slave_en,
  input  logic          use_codes,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          fld_in,
  input  logic          code_h,
  input  logic          code_v,
  input  logic          code_f,
  output logic          csync_n,
  output logic          burst_gate,
  output logic [LW-1:0] line_cnt,
  output logic [PW-1:0] pix_cnt,
  output logic          pal_active
);

  logic [LW-1:0] line_q, line_d;
  logic [PW-1:0] pix_q;
  logic          pal_q, h_q, v_q;

  wire h_raw  = use_codes ? code_h : hs_in;
  wire v_raw  = use_codes ? code_v : vs_in;
  wire f_raw  = use_codes ? code_f : fld_in;
  wire h_edge = slave_en & h_raw & ~h_q;
  wire v_edge = slave_en & v_raw & ~v_q;

  wire [PW-1:0] ppl      = pal_q ? PW'(PIX_PAL) : PW'(PIX_NTSC);
  wire [LW-1:0] lpf      = pal_q ? LW'(LINES_PAL) : LW'(LINES_NTSC);
  wire [LW-1:0] f2_first = pal_q ? LW'(LINES_PAL / 2 + 2) : LW'(LINES_NTSC / 2 + 2);

  wire eol       = pix_q >= ppl - 1'b1;
  wire step      = h_edge | eol;
  wire last_line = line_q >= lpf;
  wire new_frame = v_edge ? ~f_raw : (step & last_line);

  always_comb begin
    if (v_edge)    line_d = f_raw ? f2_first : LW'(1);
    else if (step) line_d = last_line ? LW'(1) : line_q + 1'b1;
    else           line_d = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= LW'(1);
      pix_q  <= '0;
      pal_q  <= 1'b0;
      h_q    <= 1'b0;
      v_q    <= 1'b0;
    end else begin
      line_q <= line_d;
      pix_q  <= step ? '0 : pix_q + 1'b1;
      if (new_frame) pal_q <= pal_sel;
      h_q    <= h_raw;
      v_q    <= v_raw;
    end
  end

  function automatic logic in_rng(input logic [LW-1:0] l, input int lo, input int hi);
    return (int'(l) >= lo) && (int'(l) <= hi);
  endfunction

  wire vs_line = pal_q
    ? (in_rng(line_q, VS_P1, VS_P1 + VS_LEN - 1) | in_rng(line_q, VS_P2, VS_P2 + VS_LEN - 1))
    : (in_rng(line_q, VS_N1, VS_N1 + VS_LEN - 1) | in_rng(line_q, VS_N2, VS_N2 + VS_LEN - 1));

  wire bg_line = pal_q
    ? (in_rng(line_q, BG_P1, BG_P1E) | in_rng(line_q, BG_P2, BG_P2E))
    : (in_rng(line_q, BG_N1, BG_N1E) | in_rng(line_q, BG_N2, BG_N2E));

  wire in_hs = int'(pix_q) < HS_W;
  wire tail  = int'(pix_q) >= (int'(ppl) - HS_W);

  assign csync_n    = vs_line ? tail : ~in_hs;
  assign burst_gate = bg_line & (int'(pix_q) >= BG_START) & (int'(pix_q) < BG_START + BG_LEN);
  assign line_cnt   = line_q;
  assign pix_cnt    = pix_q;
  assign pal_active = pal_q;

endmodule

// File: rtl/vid_line_timer_chk.sv
module vid_line_timer_chk #(
  parameter int PIX_PAL    = 864,
  parameter int LINES_NTSC = 525,
  parameter int LINES_PAL  = 625,
  parameter int PW         = 10,
  parameter int LW         = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_en,
  input logic          pal_active,
  input logic [LW-1:0] line_cnt,
  input logic [PW-1:0] pix_cnt,
  input logic          csync_n,
  input logic          burst_gate
);

  AST_PIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pix_cnt) < PIX_PAL);  // R2

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt >= LW'(1)) && (int'(line_cnt) <= (pal_active ? LINES_PAL : LINES_NTSC)));  // R2

  AST_STD_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_active != $past(pal_active)) |-> (line_cnt == LW'(1)));  // R3

  AST_GATE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gate |-> csync_n);  // R6

  AST_MASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(slave_en) && (pix_cnt != '0)) |-> (pix_cnt == PW'($past(pix_cnt) + 1'b1)));  // R10

endmodule

bind vid_line_timer vid_line_timer_chk #(
  .PIX_PAL(PIX_PAL), .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL), .PW(PW), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .pal_active(pal_active),
  .line_cnt(line_cnt), .pix_cnt(pix_cnt), .csync_n(csync_n), .burst_gate(burst_gate)
);

// File: tb/vid_line_timer_tb.sv
module vid_line_timer_tb;
  localparam int PN = 40, PP = 44, HW = 4, BS = 6, BL = 5, LN = 525, LP = 625;
  localparam int PWB = $clog2(PP);
  localparam int LWB = $clog2(LP + 1);

  logic clk = 1'b0, rst_n = 1'b0, pal_sel = 1'b0, slave_en = 1'b0, use_codes = 1'b0;
  logic hs_in = 1'b0, vs_in = 1'b0, fld_in = 1'b0, code_h = 1'b0, code_v = 1'b0, code_f = 1'b0;
  wire csync_n, burst_gate, pal_active;
  wire [LWB-1:0] line_cnt;
  wire [PWB-1:0] pix_cnt;

  int n_chk = 0, n_bad = 0;
  int eline = 1, epix = 0;
  bit estd = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vid_line_timer #(.PIX_NTSC(PN), .PIX_PAL(PP), .HS_W(HW), .BG_START(BS), .BG_LEN(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .slave_en(slave_en), .use_codes(use_codes),
    .hs_in(hs_in), .vs_in(vs_in), .fld_in(fld_in), .code_h(code_h), .code_v(code_v),
    .code_f(code_f), .csync_n(csync_n), .burst_gate(burst_gate), .line_cnt(line_cnt),
    .pix_cnt(pix_cnt), .pal_active(pal_active));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_cs(input int l, input int p, input bit pal);
    int ppl;
    bit v;
    ppl = pal ? PP : PN;
    v = pal ? ((l >= 1 && l <= 3) || (l >= 313 && l <= 315))
            : ((l >= 4 && l <= 6) || (l >= 266 && l <= 268));
    return v ? (p >= ppl - HW) : (p >= HW);
  endfunction

  function automatic bit exp_bg(input int l, input int p, input bit pal);
    bit ln;
    ln = pal ? ((l >= 6 && l <= 310) || (l >= 319 && l <= 623))
             : ((l >= 10 && l <= 263) || (l >= 273 && l <= 525));
    return ln && p >= BS && p < BS + BL;
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pos(input string req, input int l, input int p);
    chk(int'(line_cnt) == l, {req, " line"}, int'(line_cnt), l);
    chk(int'(pix_cnt) == p, {req, " pixel"}, int'(pix_cnt), p);
  endtask

  // R2 R3 R4 R5 R6: free-running comparison against the reference position
  task automatic run_master(input int n);
    for (int i = 0; i < n; i++) begin
      pos("R2", eline, epix);
      chk(pal_active == estd, "R3 standard", int'(pal_active), int'(estd));
      chk(csync_n == exp_cs(eline, epix, estd), "R4 R5 csync", int'(csync_n),
          int'(exp_cs(eline, epix, estd)));
      chk(burst_gate == exp_bg(eline, epix, estd), "R6 gate", int'(burst_gate),
          int'(exp_bg(eline, epix, estd)));
      @(posedge clk);
      if (epix == (estd ? PP : PN) - 1) begin
        epix = 0;
        if (eline == (estd ? LP : LN)) begin
          eline = 1;
          estd = pal_sel;
        end else eline++;
      end else epix++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    pos("R1", 1, 0);
    chk(pal_active == 1'b0, "R1 standard", int'(pal_active), 0);
    chk(csync_n == 1'b0, "R1 csync", int'(csync_n), 0);
    rst_n = 1'b1;
    eline = 1; epix = 0; estd = 1'b0;
  endtask

  task automatic t_ntsc_frame;
    run_master(PN * LN + 50);
  endtask

  task automatic t_std_change;
    pal_sel = 1'b1;
    run_master((LN - eline) * PN + (PN - epix));
    chk(pal_active == 1'b1, "R3 taken at frame start", int'(pal_active), 1);
    run_master(PP * LP + 10);
  endtask

  task automatic t_slave_pins;
    slave_en = 1'b1; hs_in = 1'b1;
    tick; pos("R7 hs restart", 2, 0);
    tick; pos("R10 held strobe", 2, 1);
    hs_in = 1'b0; vs_in = 1'b1; fld_in = 1'b1;
    tick; pos("R8 field two PAL", 314, 2);
    vs_in = 1'b0; pal_sel = 1'b0;
    tick;
    chk(pal_active == 1'b1, "R3 no change mid frame", int'(pal_active), 1);
    vs_in = 1'b1; fld_in = 1'b0;
    tick; pos("R8 field one", 1, 4);
    chk(pal_active == 1'b0, "R3 vs frame start", int'(pal_active), 0);
    vs_in = 1'b0;
    tick;
    vs_in = 1'b1; fld_in = 1'b1; hs_in = 1'b1;
    tick; pos("R8 vs over hs", 264, 0);
    vs_in = 1'b0; fld_in = 1'b0; hs_in = 1'b0;
    tick;
  endtask

  task automatic t_slave_codes;
    use_codes = 1'b1; hs_in = 1'b1;
    tick; pos("R9 pin ignored", 264, 2);
    hs_in = 1'b0; code_h = 1'b1;
    tick; pos("R9 code h", 265, 0);
    code_h = 1'b0;
    tick;
    code_v = 1'b1; code_f = 1'b1;
    tick; pos("R9 code v", 264, 2);
    code_v = 1'b0; code_f = 1'b0;
    tick;
  endtask

  task automatic t_master_ignore;
    slave_en = 1'b0; code_h = 1'b1;
    tick; pos("R10 master code", 264, 4);
    code_h = 1'b0; use_codes = 1'b0; hs_in = 1'b1;
    tick; pos("R10 master pin", 264, 5);
    hs_in = 1'b0;
    tick;
  endtask

  task automatic t_async_reset;
    #3 rst_n = 1'b0;
    #1;
    pos("R1 async", 1, 0);
    chk(pal_active == 1'b0, "R1 async standard", int'(pal_active), 0);
    chk(csync_n == 1'b0, "R1 async csync", int'(csync_n), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick; pos("R1 release", 1, 1);
  endtask

  initial begin
    t_reset;
    t_ntsc_frame;
    t_std_change;
    t_slave_pins;
    t_slave_codes;
    t_master_ignore;
    t_async_reset;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule